// File: doc/BRIEF.md
# Valley-Mode PWM Cycle Sequencer

This block is the digital timing core of a constant-on-time buck controller that regulates at the valley of the inductor current. It receives four comparator flags from the analog front end. They say whether feedback is below its reference, whether the valley current is over the limit, whether the inductor current has gone too far negative, and whether the output has come back to its target. From these flags it drives a high-side gate enable and a low-side gate enable. All durations are counted in system clock cycles.

A switching cycle starts when feedback falls below the reference. The high side is then enabled for a fixed on-time. The low side follows and holds for at least a minimum off-time. A dead time keeps both gates low on every hand-over between them. A cycle can start only while the low side conducts or the sequencer is idle, and only while the valley current is under the limit.

In forced continuous mode, a negative over-current event turns the low side off for a fixed retry delay and then turns it back on. When the output reaches its target after such a retry, the block moves to a new high-side pulse. A disable input silences both gates at once and parks the sequencer.

Top module: `valley_cot_seq`

## Requirements
- R1: After reset, and while feedback stays at or above the reference, both gate enables are low.
- R2: Each high-side pulse lasts exactly ON_CYCLES clock cycles.
- R3: After each on-time the low side stays on for at least MIN_OFF_CYCLES cycles. If feedback is still below the reference when that time ends, the next high-side pulse rises exactly ON_CYCLES + 2*DEAD_CYCLES + MIN_OFF_CYCLES cycles after the previous one rose.
- R4: While the valley-over-limit flag is high, no high-side pulse starts, even if feedback is low. Once the flag clears with feedback still low, a pulse rises within DEAD_CYCLES + 3 cycles.
- R5: When continuous mode is selected and the negative-limit flag is seen while the low side is in its free (post minimum off-time) phase, the low side turns off for exactly RETRY_CYCLES cycles and then turns back on. This repeats on every new hit.
- R6: When continuous mode is not selected (ccmMode = 0), the negative-limit flag has no effect and the low side stays on.
- R7: If the output-at-target flag is seen after at least one negative-limit retry, the low side turns off and a high-side pulse follows after the dead time. Without a preceding retry, the flag has no effect.
- R8: Between a high-side fall and the next low-side rise, and between a low-side fall and the next high-side rise, both enables are low for exactly DEAD_CYCLES cycles.
- R9: The two gate enables are never high in the same cycle.
- R10: While haltAll is high, both enables are low in that same cycle and no cycle starts. After release the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| haltAll | input | 1 | Global disable; forces both gates low and returns to idle |
| fbLow | input | 1 | Feedback is below the reference |
| valleyOver | input | 1 | Valley current is above the positive limit |
| negOver | input | 1 | Inductor current is beyond the negative limit |
| atTarget | input | 1 | Output has discharged to its target |
| ccmMode | input | 1 | 1 selects forced continuous conduction |
| hsGate | output | 1 | High-side gate enable |
| lsGate | output | 1 | Low-side gate enable |

## Verification
Two functions can fall in the same cycle. A cycle start request (feedback low) can arrive together with a negative-limit hit while the low side is free, and the minimum off-time can expire in the cycle when feedback is already low. The random phase holds feedback, valley and negative flags at independent densities so these collisions happen often. The monitor judges each outcome by the shape of the gates: every high pulse must be exactly the on-time, every hand-over exactly the dead time, and every low-side gap after a retry exactly the retry delay, whichever request won.

// File: rtl/valley_seq_pkg.sv
package valley_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEAD_HL,
    ST_HIGH,
    ST_DEAD_LH,
    ST_MINOFF,
    ST_LOW,
    ST_NEG_OFF
  } seq_state_e;

  typedef enum logic [1:0] {
    TM_DEAD,
    TM_ON,
    TM_MINOFF,
    TM_RETRY
  } timer_sel_e;

  typedef struct packed {
    logic       load;
    timer_sel_e sel;
  } timer_cmd_t;

endpackage

// File: rtl/valley_seq_timer.sv
module valley_seq_timer
  import valley_seq_pkg::*;
#(
  parameter int ON_CYCLES      = 20,
  parameter int MIN_OFF_CYCLES = 20,
  parameter int RETRY_CYCLES   = 20,
  parameter int DEAD_CYCLES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  timer_cmd_t cmd,
  output logic       expired
);

  localparam int MAX_A  = (ON_CYCLES > MIN_OFF_CYCLES) ? ON_CYCLES : MIN_OFF_CYCLES;
  localparam int MAX_B  = (RETRY_CYCLES > DEAD_CYCLES) ? RETRY_CYCLES : DEAD_CYCLES;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  logic [CW-1:0] count;
  logic [CW-1:0] reloadVal;

  // Load value is the duration minus one, so the state lasts exactly that many cycles
  always_comb begin
    unique case (cmd.sel)
      TM_DEAD:   reloadVal = CW'(DEAD_CYCLES - 1);
      TM_ON:     reloadVal = CW'(ON_CYCLES - 1);
      TM_MINOFF: reloadVal = CW'(MIN_OFF_CYCLES - 1);
      default:   reloadVal = CW'(RETRY_CYCLES - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (cmd.load) begin
      count <= reloadVal;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign expired = (count == '0);

endmodule

// File: rtl/valley_seq_ctrl.sv
module valley_seq_ctrl
  import valley_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       haltAll,
  input  logic       fbLow,
  input  logic       valleyOver,
  input  logic       negOver,
  input  logic       atTarget,
  input  logic       ccmMode,
  input  logic       expired,
  output timer_cmd_t cmd,
  output logic       hsOn,
  output logic       lsOn
);

  seq_state_e curState, nextState;
  logic       negMode, negModeNext;
  logic       startReq;

  // A new on-time needs the valley current under the limit; the target flag
  // only counts as a start request after a negative-limit retry
  assign startReq = !valleyOver && (fbLow || (negMode && atTarget));

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_IDLE:    if (startReq) nextState = ST_DEAD_HL;
      ST_DEAD_HL: if (expired)  nextState = ST_HIGH;
      ST_HIGH:    if (expired)  nextState = ST_DEAD_LH;
      ST_DEAD_LH: if (expired)  nextState = ST_MINOFF;
      ST_MINOFF:  if (expired)  nextState = startReq ? ST_DEAD_HL : ST_LOW;
      ST_LOW: begin
        if (startReq)                nextState = ST_DEAD_HL;
        else if (ccmMode && negOver) nextState = ST_NEG_OFF;
      end
      ST_NEG_OFF: if (expired)  nextState = ST_LOW;
      default:                  nextState = ST_IDLE;
    endcase
    if (haltAll) nextState = ST_IDLE;
  end

  always_comb begin
    negModeNext = negMode;
    if (nextState == ST_NEG_OFF)                              negModeNext = 1'b1;
    else if (nextState == ST_DEAD_HL || nextState == ST_IDLE) negModeNext = 1'b0;
  end

  always_comb begin
    cmd.load = (nextState != curState) && (nextState != ST_IDLE) && (nextState != ST_LOW);
    unique case (nextState)
      ST_HIGH:    cmd.sel = TM_ON;
      ST_MINOFF:  cmd.sel = TM_MINOFF;
      ST_NEG_OFF: cmd.sel = TM_RETRY;
      default:    cmd.sel = TM_DEAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curState <= ST_IDLE;
      negMode  <= 1'b0;
    end else begin
      curState <= nextState;
      negMode  <= negModeNext;
    end
  end

  assign hsOn = (curState == ST_HIGH);
  assign lsOn = (curState == ST_MINOFF) || (curState == ST_LOW);

endmodule

// File: rtl/valley_cot_seq.sv
module valley_cot_seq
  import valley_seq_pkg::*;
#(
  parameter int ON_CYCLES      = 20,
  parameter int MIN_OFF_CYCLES = 20,
  parameter int RETRY_CYCLES   = 20,
  parameter int DEAD_CYCLES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic haltAll,
  input  logic fbLow,
  input  logic valleyOver,
  input  logic negOver,
  input  logic atTarget,
  input  logic ccmMode,
  output logic hsGate,
  output logic lsGate
);

  timer_cmd_t timerCmd;
  logic       timerExpired;
  logic       hsOn, lsOn;

  valley_seq_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .haltAll    (haltAll),
    .fbLow      (fbLow),
    .valleyOver (valleyOver),
    .negOver    (negOver),
    .atTarget   (atTarget),
    .ccmMode    (ccmMode),
    .expired    (timerExpired),
    .cmd        (timerCmd),
    .hsOn       (hsOn),
    .lsOn       (lsOn)
  );

  valley_seq_timer #(
    .ON_CYCLES      (ON_CYCLES),
    .MIN_OFF_CYCLES (MIN_OFF_CYCLES),
    .RETRY_CYCLES   (RETRY_CYCLES),
    .DEAD_CYCLES    (DEAD_CYCLES)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (timerCmd),
    .expired (timerExpired)
  );

  // The disable input blanks the gates in the same cycle it is raised
  assign hsGate = hsOn && !haltAll;
  assign lsGate = lsOn && !haltAll;

endmodule

// File: rtl/valley_cot_seq_checker.sv
module valley_cot_seq_checker #(
  parameter int ON_CYCLES   = 20,
  parameter int DEAD_CYCLES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic haltAll,
  input logic hsGate,
  input logic lsGate
);

  logic [15:0] hsRun;
  logic [15:0] lowRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsRun  <= '0;
      lowRun <= '0;
    end else begin
      hsRun  <= hsGate ? hsRun + 1'b1 : '0;
      if (hsGate || lsGate) lowRun <= '0;
      else if (lowRun != 16'hFFFF) lowRun <= lowRun + 1'b1;
    end
  end

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hsGate && lsGate));

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    haltAll |-> (!hsGate && !lsGate));

  assert_on_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hsGate) && !haltAll) |-> (hsRun == 16'(ON_CYCLES)));

  assert_dead_before_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsGate) |-> (lowRun >= 16'(DEAD_CYCLES)));

  assert_dead_before_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsGate) |-> (lowRun >= 16'(DEAD_CYCLES)));

endmodule

bind valley_cot_seq valley_cot_seq_checker #(
  .ON_CYCLES   (ON_CYCLES),
  .DEAD_CYCLES (DEAD_CYCLES)
) i_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .haltAll (haltAll),
  .hsGate  (hsGate),
  .lsGate  (lsGate)
);

// File: tb/test_valley_cot_seq.sv
module test_valley_cot_seq;

  localparam int ON  = 20;
  localparam int MO  = 20;
  localparam int RT  = 20;
  localparam int DT  = 2;
  localparam int PERIOD = ON + 2*DT + MO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic haltAll = 0, fbLow = 0, valleyOver = 0, negOver = 0, atTarget = 0, ccmMode = 1;
  logic hsGate, lsGate;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  valley_cot_seq #(.ON_CYCLES(ON), .MIN_OFF_CYCLES(MO), .RETRY_CYCLES(RT), .DEAD_CYCLES(DT))
  i_valley_cot_seq (
    .clk(clk), .rst_n(rst_n), .haltAll(haltAll), .fbLow(fbLow), .valleyOver(valleyOver),
    .negOver(negOver), .atTarget(atTarget), .ccmMode(ccmMode), .hsGate(hsGate), .lsGate(lsGate)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expectedPeriod();
    return PERIOD;
  endfunction

  // Monitor: samples mid-cycle, judges pulse shapes
  bit monOn = 0;
  int cyc = 0, hsRun = 0, lsRun = 0, lowRun = 0, lastFell = 0;
  int hsRises = 0, lastRiseCyc = 0, riseGap = 0, lsRunLast = 0;
  bit prevH = 0, prevL = 0;

  always @(negedge clk) begin
    cyc++;
    if (monOn) begin
      check(!(hsGate && lsGate), "R9 overlap", int'(hsGate && lsGate), 0);
      if (hsGate && !prevH && lastFell != 0) check(lowRun == DT, "R8 dead before high", lowRun, DT);
      if (!hsGate && prevH) check(hsRun == ON, "R2 on width", hsRun, ON);
      if (lsGate && !prevL && lastFell == 1) check(lowRun == DT, "R8 dead before low", lowRun, DT);
      if (lsGate && !prevL && lastFell == 2) check(lowRun == RT, "R5 retry gap", lowRun, RT);
    end
    if (hsGate && !prevH) begin
      hsRises++;
      riseGap = cyc - lastRiseCyc;
      lastRiseCyc = cyc;
    end
    if (!lsGate && prevL) lsRunLast = lsRun;
    if (!monOn) lastFell = 0;
    else if (!hsGate && prevH) lastFell = 1;
    else if (!lsGate && prevL) lastFell = 2;
    hsRun  = hsGate ? hsRun + 1 : 0;
    lsRun  = lsGate ? lsRun + 1 : 0;
    lowRun = (hsGate || lsGate) ? 0 : lowRun + 1;
    prevH = hsGate;
    prevL = lsGate;
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic settle(); @(negedge clk); #1; endtask

  task automatic waitRise(input int limit, output bit seen, output int waited);
    int start = hsRises;
    seen = 0;
    waited = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      settle();
      waited++;
      if (hsRises != start) seen = 1;
    end
  endtask

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishTest();
  end

  initial begin
    bit seen;
    int waited, r0, bad;
    void'($urandom(32'd4711));
    repeat (4) tick();
    rst_n = 1'b1;
    // R1: quiet after reset
    settle();
    check(!hsGate && !lsGate, "R1 reset gates", int'({hsGate, lsGate}), 0);
    repeat (20) tick();
    settle();
    check(!hsGate && !lsGate, "R1 idle without request", int'({hsGate, lsGate}), 0);
    monOn = 1;

    // R2/R3: feedback held low, back-to-back cycles
    tick(); fbLow = 1;
    waitRise(10, seen, waited);
    check(seen, "R2 first start", int'(seen), 1);
    waitRise(PERIOD + 5, seen, waited);
    check(seen && riseGap == expectedPeriod(), "R3 repeat period", riseGap, expectedPeriod());
    check(lsRunLast == MO, "R3 min off length", lsRunLast, MO);
    waitRise(PERIOD + 5, seen, waited);
    check(seen && riseGap == expectedPeriod(), "R3 repeat period 2", riseGap, expectedPeriod());
    tick(); fbLow = 0;
    repeat (80) tick();
    settle();
    check(lsGate && !hsGate, "R3 low side holds", int'({hsGate, lsGate}), 1);

    // R4: valley limit blocks starts
    tick(); fbLow = 1; valleyOver = 1;
    r0 = hsRises;
    repeat (80) tick();
    check(hsRises == r0, "R4 blocked start", hsRises - r0, 0);
    valleyOver = 0;
    waitRise(DT + 3, seen, waited);
    check(seen, "R4 start after release", waited, DT + 3);
    tick(); fbLow = 0;
    repeat (80) tick();

    // R6: negative limit ignored outside continuous mode
    ccmMode = 0; negOver = 1;
    bad = 0;
    for (int i = 0; i < 40; i++) begin settle(); if (!lsGate) bad++; end
    check(bad == 0, "R6 DCM ignores negative limit", bad, 0);
    tick(); negOver = 0; ccmMode = 1;

    // R7: target flag without a retry does nothing
    atTarget = 1;
    r0 = hsRises; bad = 0;
    for (int i = 0; i < 40; i++) begin settle(); if (!lsGate) bad++; end
    check(bad == 0 && hsRises == r0, "R7 target ignored without retry", bad, 0);
    tick(); atTarget = 0;

    // R5: retry loop, twice
    for (int k = 0; k < 2; k++) begin
      tick(); negOver = 1;
      tick(); negOver = 0;
      settle();
      check(!lsGate, "R5 low side released", int'(lsGate), 0);
      repeat (RT + 4) tick();
      settle();
      check(lsGate, "R5 low side retried", int'(lsGate), 1);
    end
    // R7: target after retry starts a pulse
    tick(); atTarget = 1;
    waitRise(DT + 4, seen, waited);
    check(seen, "R7 resume after target", waited, DT + 3);
    tick(); atTarget = 0;
    repeat (80) tick();

    // Random phase: overlapping requests
    for (int i = 0; i < 4000; i++) begin
      tick();
      if (i % 200 == 0) ccmMode = ($urandom % 4) != 0;
      fbLow      = ($urandom % 8) == 0;
      valleyOver = ($urandom % 4) == 0;
      negOver    = ($urandom % 10) == 0;
      atTarget   = ($urandom % 6) == 0;
    end
    tick(); fbLow = 0; valleyOver = 0; negOver = 0; atTarget = 0; ccmMode = 1;
    repeat (60) tick();

    // R10: halt while the high side conducts
    monOn = 0;
    tick(); fbLow = 1;
    waitRise(200, seen, waited);
    check(seen, "R10 pulse before halt", int'(seen), 1);
    @(posedge clk); #2; haltAll = 1;
    #1;
    check(!hsGate && !lsGate, "R10 immediate blank", int'({hsGate, lsGate}), 0);
    bad = 0;
    for (int i = 0; i < 10; i++) begin settle(); if (hsGate || lsGate) bad++; end
    check(bad == 0, "R10 stays quiet", bad, 0);
    tick(); haltAll = 0; fbLow = 0;
    bad = 0;
    for (int i = 0; i < 30; i++) begin settle(); if (hsGate || lsGate) bad++; end
    check(bad == 0, "R10 idle after release", bad, 0);
    monOn = 1;
    tick(); fbLow = 1;
    waitRise(DT + 3, seen, waited);
    check(seen, "R2 restart from idle", waited, DT + 3);
    tick(); fbLow = 0;
    repeat (80) tick();
    finishTest();
  end

endmodule